// File: doc/BRIEF.md
# Memory-mapped event counter unit

This block is a performance-monitoring unit with a bank of wide event counters that software programs and reads over a simple 64-bit register port. Each counter has its own selector. The selector either counts every clock or follows one of the incoming event lines. Software reads the live count at any time and can overwrite it, for example with zero to restart a measurement. Counters run only while a global enable bit and their own enable bit are both set.

Counter enables and interrupt enables are each held in one mask. Each mask has two addresses: writing ones to the set address turns bits on, and writing ones to the clear address turns them off. When a counter wraps from all ones to zero, it raises a sticky overflow flag. Software clears the flag by writing a one to it. A single level interrupt is high while any flagged counter also has its interrupt enabled. A bit in the global control word clears every counter at once.

The register port is a single address, used for both reads and writes. Reads are combinational. A write takes effect at the next rising clock edge.

Top module: `evcnt_unit`

## Requirements
- R1: After reset, every counter, selector, counter enable, interrupt enable and overflow flag reads 0, the global enable reads 0 and `irq` is low.
- R2: A counter adds one on each clock where the global enable, its own enable and its selected event are all high. Selector 0x00 means every clock. Selector k in 1..NUM_EV follows `ev_in[k-1]`. Any other selector value never counts.
- R3: The event selector of counter n is at 0x200+8n. Bits [7:0] are stored. The upper bits of a write are dropped, and the upper bits of a read return 0.
- R4: The counter-enable mask is set at 0x410 and cleared at 0x418, one bit per counter. Zero bits in a write leave the mask unchanged. Reading either address returns the mask.
- R5: The interrupt-enable mask is set at 0x420 and cleared at 0x428, with the same bit rules as R4. Reading either address returns the mask.
- R6: The counter value of counter n is at 0x000+8n. A write to it loads the written value and takes precedence over an increment in the same clock. A read returns the current count.
- R7: When an increment takes a counter from all ones to zero, overflow bit n at 0x440 is set on that same clock edge.
- R8: Writing a 1 to an overflow bit clears it, and zero bits leave the register unchanged. If a clear and a new overflow hit the same bit in the same clock, the bit stays set.
- R9: `irq` is high exactly when some counter has both its overflow bit and its interrupt-enable bit set.
- R10: The global control word is at 0x400. Bit 0 is the global enable and reads back. Writing bit 1 as 1 zeroes all counters on that clock, without raising any overflow, and bit 1 reads 0.
- R11: The per-counter control word at 0x100+8n always reads 0. Writes to it change nothing.
- R12: A misaligned address (bits [2:0] not zero), an index at or above NUM_CNT, or an address in no register region reads 0. A write to any such address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 11 | Byte address of the register to read or write |
| wr_data | input | DATA_W (64) | Write data |
| rd_data | output | DATA_W (64) | Combinational read data for `addr` |
| ev_in | input | NUM_EV (16) | Event lines, sampled on each clock |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a counter up to just below all ones and lets it wrap. A wrong carry detector would either miss the overflow flag or raise it one clock late. A status clear is issued in the same clock as a fresh wrap, so a design that gives the clear priority would lose that overflow. Writes of zero bits to every set and clear address catch a mask that is loaded instead of merged. Selector codes 16, 17 and 0xFF test the edge of the event range, where an off-by-one would count on a line that is not connected. A counter is written in a clock where it would otherwise increment, to check that the written value wins. The misaligned, out-of-range and unmapped addresses are each written and then read back.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int REG_ADDR_W = 11;

  // address bits [10:8] pick a region, bits [7:3] a slot inside it
  localparam logic [2:0] REG_CNT = 3'd0;
  localparam logic [2:0] REG_CTL = 3'd1;
  localparam logic [2:0] REG_TYP = 3'd2;
  localparam logic [2:0] REG_GLB = 3'd4;

  localparam logic [4:0] SLOT_GCR     = 5'd0;
  localparam logic [4:0] SLOT_CEN_SET = 5'd2;
  localparam logic [4:0] SLOT_CEN_CLR = 5'd3;
  localparam logic [4:0] SLOT_IEN_SET = 5'd4;
  localparam logic [4:0] SLOT_IEN_CLR = 5'd5;
  localparam logic [4:0] SLOT_STS     = 5'd8;

  typedef struct packed {
    logic cnt;
    logic ctl;
    logic typ;
    logic gcr;
    logic cen_set;
    logic cen_clr;
    logic ien_set;
    logic ien_clr;
    logic sts;
  } hit_t;
endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int IDX_W   = 3
) (
  input  logic [REG_ADDR_W-1:0] addr,
  output hit_t                  hit,
  output logic [IDX_W-1:0]      idx
);
  logic [2:0] region;
  logic [4:0] slot;
  logic       aligned;
  logic       in_range;

  assign region   = addr[10:8];
  assign slot     = addr[7:3];
  assign aligned  = (addr[2:0] == 3'd0);
  assign in_range = aligned && (32'(slot) < NUM_CNT);
  assign idx      = slot[IDX_W-1:0];

  always_comb begin
    hit = '0;
    unique case (region)
      REG_CNT: hit.cnt = in_range;
      REG_CTL: hit.ctl = in_range;
      REG_TYP: hit.typ = in_range;
      REG_GLB: begin
        hit.gcr     = aligned && (slot == SLOT_GCR);
        hit.cen_set = aligned && (slot == SLOT_CEN_SET);
        hit.cen_clr = aligned && (slot == SLOT_CEN_CLR);
        hit.ien_set = aligned && (slot == SLOT_IEN_SET);
        hit.ien_clr = aligned && (slot == SLOT_IEN_CLR);
        hit.sts     = aligned && (slot == SLOT_STS);
      end
      default: hit = '0;
    endcase
  end
endmodule

// File: rtl/evcnt_mask.sv
module evcnt_mask #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_v) & ~clr_v;
  end
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 8,
  parameter int NUM_EV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              cnt_wr,
  input  logic              sel_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run,
  input  logic [NUM_EV-1:0] ev_in,
  output logic [DATA_W-1:0] cnt_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              inc,
  output logic              ovf
);
  // selector 0 counts every clock, k in 1..NUM_EV follows ev_in[k-1]
  function automatic logic sel_hit(input logic [SEL_W-1:0] s,
                                   input logic [NUM_EV-1:0] ev);
    logic h;
    h = (s == '0);
    for (int k = 0; k < NUM_EV; k++)
      if (int'(s) == k + 1) h = ev[k];
    return h;
  endfunction

  // count + 1 with the carry out in the top bit
  function automatic logic [DATA_W:0] bump(input logic [DATA_W-1:0] v);
    return {1'b0, v} + (DATA_W + 1)'(1);
  endfunction

  logic [DATA_W:0] nxt;

  assign inc = run & sel_hit(sel_q, ev_in);
  assign nxt = bump(cnt_q);
  assign ovf = inc & nxt[DATA_W] & ~clear_all & ~cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear_all) cnt_q <= '0;
    else if (cnt_wr)    cnt_q <= wdata;
    else if (inc)       cnt_q <= nxt[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= wdata[SEL_W-1:0];
  end
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int DATA_W  = 64,
  parameter int SEL_W   = 8,
  parameter int NUM_EV  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_EV-1:0]     ev_in,
  output logic                  irq
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  hit_t             hit;
  logic [IDX_W-1:0] idx;

  logic [DATA_W-1:0]  cnt_q [NUM_CNT];
  logic [SEL_W-1:0]   sel_q [NUM_CNT];
  logic [NUM_CNT-1:0] wr_cnt_v, wr_sel_v, run_v;
  logic [NUM_CNT-1:0] inc_v, ovf_v, cnt_nz_v;
  logic [NUM_CNT-1:0] cen_q, ien_q, sts_q;
  logic [NUM_CNT-1:0] cen_set_v, cen_clr_v, ien_set_v, ien_clr_v, sts_w1c_v;
  logic               gen_q;
  logic               cnt_rst_w;

  evcnt_decode #(.NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .hit(hit), .idx(idx)
  );

  assign cen_set_v = (wr_en && hit.cen_set) ? wr_data[NUM_CNT-1:0] : '0;
  assign cen_clr_v = (wr_en && hit.cen_clr) ? wr_data[NUM_CNT-1:0] : '0;
  assign ien_set_v = (wr_en && hit.ien_set) ? wr_data[NUM_CNT-1:0] : '0;
  assign ien_clr_v = (wr_en && hit.ien_clr) ? wr_data[NUM_CNT-1:0] : '0;
  assign sts_w1c_v = (wr_en && hit.sts)     ? wr_data[NUM_CNT-1:0] : '0;
  assign cnt_rst_w = wr_en && hit.gcr && wr_data[1];

  evcnt_mask #(.N(NUM_CNT)) u_cen (
    .clk(clk), .rst_n(rst_n), .set_v(cen_set_v), .clr_v(cen_clr_v), .q(cen_q)
  );
  evcnt_mask #(.N(NUM_CNT)) u_ien (
    .clk(clk), .rst_n(rst_n), .set_v(ien_set_v), .clr_v(ien_clr_v), .q(ien_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gen_q <= 1'b0;
    else if (wr_en && hit.gcr) gen_q <= wr_data[0];
  end

  // a fresh overflow outranks a clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~sts_w1c_v) | ovf_v;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign wr_cnt_v[g] = wr_en && hit.cnt && (32'(idx) == g);
    assign wr_sel_v[g] = wr_en && hit.typ && (32'(idx) == g);
    assign run_v[g]    = gen_q && cen_q[g];
    assign cnt_nz_v[g] = |cnt_q[g];

    evcnt_slice #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_EV(NUM_EV)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .clear_all(cnt_rst_w), .cnt_wr(wr_cnt_v[g]), .sel_wr(wr_sel_v[g]),
      .wdata(wr_data), .run(run_v[g]), .ev_in(ev_in),
      .cnt_q(cnt_q[g]), .sel_q(sel_q[g]), .inc(inc_v[g]), .ovf(ovf_v[g])
    );
  end

  assign irq = |(sts_q & ien_q);

  always_comb begin
    rd_data = '0;
    if (hit.cnt)                      rd_data = cnt_q[idx];
    else if (hit.typ)                 rd_data = DATA_W'(sel_q[idx]);
    else if (hit.ctl)                 rd_data = '0;
    else if (hit.gcr)                 rd_data = DATA_W'(gen_q);
    else if (hit.cen_set || hit.cen_clr) rd_data = DATA_W'(cen_q);
    else if (hit.ien_set || hit.ien_clr) rd_data = DATA_W'(ien_q);
    else if (hit.sts)                 rd_data = DATA_W'(sts_q);
  end
endmodule

// File: rtl/evcnt_unit_chk.sv
module evcnt_unit_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         gen_q,
  input logic         cnt_rst_w,
  input logic [N-1:0] inc_v,
  input logic [N-1:0] ovf_v,
  input logic [N-1:0] cen_q,
  input logic [N-1:0] ien_q,
  input logic [N-1:0] sts_q,
  input logic [N-1:0] sts_w1c_v,
  input logic [N-1:0] cnt_nz_v
);
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> (inc_v == '0));

  a_r2_inc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_v & ~cen_q) == '0);

  a_r7_ovf_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_v != '0) |=> ((sts_q & $past(ovf_v)) == $past(ovf_v)));

  a_r7_ovf_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_v != '0) |=> ((cnt_nz_v & $past(ovf_v)) == '0));

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w1c_v == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));

  a_r9_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0));

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_w |=> (cnt_nz_v == '0));
endmodule

bind evcnt_unit evcnt_unit_chk #(.N(NUM_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .gen_q(gen_q), .cnt_rst_w(cnt_rst_w),
  .inc_v(inc_v), .ovf_v(ovf_v), .cen_q(cen_q), .ien_q(ien_q), .sts_q(sts_q),
  .sts_w1c_v(sts_w1c_v), .cnt_nz_v(cnt_nz_v)
);

// File: tb/evcnt_unit_test.sv
module evcnt_unit_test;
  timeunit 1ns;
  timeprecision 10ps;

  localparam int NC = 8;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [NE-1:0] ev_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evcnt_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ev_in(ev_in), .irq(irq)
  );

  // behavioural reference state
  logic [63:0] m_cnt [NC];
  logic [7:0]  m_sel [NC];
  logic [7:0]  m_cen, m_ien, m_sts;
  logic        m_gen;

  function automatic bit m_event(int i);
    int s = int'(m_sel[i]);
    if (s == 0) return 1'b1;
    if (s <= NE) return ev_in[s-1];
    return 1'b0;
  endfunction

  task automatic model_step(bit w, int a, logic [63:0] d);
    logic [63:0] c2 [NC];
    logic [7:0]  s2 [NC];
    logic [7:0]  wrap = '0;
    for (int i = 0; i < NC; i++) begin
      bit go = m_gen && m_cen[i] && m_event(i);
      c2[i] = m_cnt[i];
      s2[i] = m_sel[i];
      if (w && a == 'h400 && d[1]) c2[i] = 0;
      else if (w && a == i * 8) c2[i] = d;
      else if (go) begin
        if (m_cnt[i] == '1) wrap[i] = 1'b1;
        c2[i] = m_cnt[i] + 64'd1;
      end
      if (w && a == 'h200 + i * 8) s2[i] = d[7:0];
    end
    if (w && a == 'h440) m_sts = m_sts & ~d[7:0];
    m_sts = m_sts | wrap;
    if (w && a == 'h400) m_gen = d[0];
    if (w && a == 'h410) m_cen = m_cen | d[7:0];
    if (w && a == 'h418) m_cen = m_cen & ~d[7:0];
    if (w && a == 'h420) m_ien = m_ien | d[7:0];
    if (w && a == 'h428) m_ien = m_ien & ~d[7:0];
    for (int i = 0; i < NC; i++) begin
      m_cnt[i] = c2[i];
      m_sel[i] = s2[i];
    end
  endtask

  function automatic logic [63:0] model_read(int a);
    for (int i = 0; i < NC; i++) begin
      if (a == i * 8) return m_cnt[i];
      if (a == 'h100 + i * 8) return 64'd0;
      if (a == 'h200 + i * 8) return {56'd0, m_sel[i]};
    end
    case (a)
      'h400: return {63'd0, m_gen};
      'h410, 'h418: return {56'd0, m_cen};
      'h420, 'h428: return {56'd0, m_ien};
      'h440: return {56'd0, m_sts};
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit w, int a, logic [63:0] d);
    wr_en = w;
    addr = 11'(a);
    wr_data = d;
    model_step(w, a, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 irq", {63'd0, irq}, {63'd0, |(m_sts & m_ien)});
  endtask

  task automatic wr(int a, logic [63:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 0, 64'd0);
  endtask

  task automatic rd(string tag, int a);
    addr = 11'(a);
    #0.1;
    chk(tag, rd_data, model_read(a));
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < NC; i++) begin
      rd(tag, i * 8);
      rd(tag, 'h100 + i * 8);
      rd(tag, 'h200 + i * 8);
    end
    rd(tag, 'h400);
    rd(tag, 'h410);
    rd(tag, 'h418);
    rd(tag, 'h420);
    rd(tag, 'h428);
    rd(tag, 'h440);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      m_cnt[i] = '0;
      m_sel[i] = '0;
    end
    m_cen = '0; m_ien = '0; m_sts = '0; m_gen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1");
    chk("R1 irq", {63'd0, irq}, 64'd0);

    // R3: selectors, including the edges of the event range
    wr('h200, 64'd0);
    wr('h208, 64'd3);
    wr('h218, 64'd16);
    wr('h220, 64'd17);
    wr('h228, 64'hFF);
    wr('h230, 64'hABCD_0000_0000_0105);
    rd("R3", 'h230);
    chk("R3 upper bits", rd_data, 64'h5);

    // R2: count under several event patterns
    wr('h410, 64'h7B);
    wr('h400, 64'h1);
    for (int k = 0; k < 12; k++) begin
      ev_in = 16'(k * 16'h1357) ^ ((k % 3 == 0) ? 16'h8004 : 16'h0);
      idle(1);
    end
    ev_in = '1;
    idle(3);
    read_all("R2");

    // R4: clear one enable, zero-bit writes leave the mask
    wr('h418, 64'h02);
    wr('h410, 64'h0);
    wr('h418, 64'h0);
    read_all("R4");
    idle(5);
    read_all("R4");

    // R10: global enable off stops everything
    wr('h400, 64'h0);
    idle(4);
    read_all("R10");
    wr('h400, 64'h1);

    // R6: direct load wins over an increment in the same clock
    wr('h018, 64'h1234_5678_9ABC_DEF0);
    rd("R6", 'h018);
    chk("R6 load", rd_data, 64'h1234_5678_9ABC_DEF0);
    idle(3);
    rd("R6", 'h018);

    // R11: control words hold nothing
    wr('h100, '1);
    wr('h138, 64'h55);
    read_all("R11");

    // R7 and R5: wrap near all ones
    wr('h210, 64'd0);
    wr('h010, 64'hFFFF_FFFF_FFFF_FFFD);
    wr('h410, 64'h04);
    idle(4);
    read_all("R7");
    chk("R7 flag", {56'd0, m_sts} & 64'h4, 64'h4);
    wr('h420, 64'h04);
    chk("R9 raised", {63'd0, irq}, 64'd1);
    wr('h420, 64'h0);
    wr('h428, 64'h0);
    read_all("R5");
    wr('h428, 64'h04);
    chk("R9 masked", {63'd0, irq}, 64'd0);
    wr('h420, 64'h04);

    // R8: zero bits keep, clear colliding with a new wrap keeps
    wr('h440, 64'h0);
    rd("R8", 'h440);
    wr('h010, '1);
    wr('h440, 64'h04);
    read_all("R8");
    chk("R8 collision", {63'd0, irq}, 64'd1);
    wr('h440, 64'h04);
    read_all("R8");

    // R10: reset bit zeroes every counter
    idle(2);
    wr('h400, 64'h3);
    read_all("R10");
    idle(2);
    read_all("R10");

    // R12: holes in the map
    wr('h7F8, '1);
    wr('h040, '1);
    wr('h404, 64'h0);
    wr('h212, 64'h9);
    rd("R12", 'h7F8);
    rd("R12", 'h040);
    rd("R12", 'h404);
    rd("R12", 'h212);
    read_all("R12");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule